// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block is a 128-bit SIMD execution unit for quantized integer kernels such as 8-bit matrix multiplication. It splits each of its two source vectors into four 32-bit lanes of four bytes each. In every lane it multiplies the four byte pairs, adds the four products together, and adds that sum to the matching 32-bit lane of an incoming accumulator vector. A 2-bit mode selects, for each source on its own, whether its bytes are signed or unsigned. This covers signed by signed, unsigned by unsigned, and both mixed forms.

Operations enter on a valid/ready port. An operation is accepted on a rising edge where `op_valid` and `op_ready` are both high. Results leave on a valid/ready port. A result stays in place, unchanged, until it is taken on an edge where `res_valid` and `res_ready` are both high. The pipeline has two stages and no extra buffering. While a result waits for `res_ready`, the whole pipe stalls and `op_ready` stays low. When `res_ready` is held high, the unit takes one operation per cycle.

Top module: `dp8_dot_acc`

## Requirements
- R1: When `op_mode` = 2'b00, both operands' bytes are signed, and each result lane j equals acc lane j plus the sum over k of a[j][k]·b[j][k].
- R2: When `op_mode` = 2'b01, both operands' bytes are treated as unsigned (0..255).
- R3: When `op_mode` = 2'b10, bytes of `op_a` are unsigned and bytes of `op_b` are signed.
- R4: When `op_mode` = 2'b11, bytes of `op_a` are signed and bytes of `op_b` are unsigned.
- R5: Byte k of lane j is bits [32j+8k+7 : 32j+8k] of a source, and lane j of the accumulator and of the result is bits [32j+31 : 32j].
- R6: Each lane sum wraps modulo 2^32, with no saturation.
- R7: Extreme products (-128·-128, 255·-128, 255·255) in all four byte positions give exact lane sums, so no intermediate term overflows.
- R8: With `res_ready` held high, a result is valid on the second rising edge after its operation is accepted, and one operation is accepted per cycle.
- R9: While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` hold their values and `op_ready` is low. An operation already inside the pipe is not lost.
- R10: During and right after reset, `res_valid` is low and `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation can be taken this cycle |
| op_a | input | 128 | First source, sixteen bytes |
| op_b | input | 128 | Second source, sixteen bytes |
| op_acc | input | 128 | Accumulator vector, four 32-bit lanes |
| op_mode | input | 2 | Signedness: 00 s·s, 01 u·u, 10 u·s, 11 s·u |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | 128 | Accumulated result, four 32-bit lanes |

## Verification
An operation accepted on rising edge e0 has its result registered at edge e1. The result is therefore visible on the falling edge that follows e1. The bench drives its inputs on falling edges and reads outputs on the next falling edges. It also checks that `res_valid` is still low on the falling edge between e0 and e1. In the streaming test, the result of the operation driven in slot c is read in slot c+2. In the stall test, the held result is read on several falling edges while `res_ready` is low. After `res_ready` returns high, the queued second result is expected exactly one edge later.

// File: rtl/dp8_pkg.sv
package dp8_pkg;

  typedef enum logic [1:0] {
    MODE_SS = 2'b00,
    MODE_UU = 2'b01,
    MODE_US = 2'b10,
    MODE_SU = 2'b11
  } dp_mode_e;

  // First operand bytes are signed in the s*s and s*u forms
  function automatic logic first_signed(input logic [1:0] m);
    return (m == MODE_SS) || (m == MODE_SU);
  endfunction

  // Second operand bytes are signed in the s*s and u*s forms
  function automatic logic second_signed(input logic [1:0] m);
    return (m == MODE_SS) || (m == MODE_US);
  endfunction

endpackage

// File: rtl/dp8_mul_stage.sv
module dp8_mul_stage #(
  parameter int unsigned EW    = 8,
  parameter int unsigned ELEMS = 4,
  parameter int unsigned LANES = 4,
  parameter int unsigned AW    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          in_valid,
  input  logic [LANES*AW-1:0]           a,
  input  logic [LANES*AW-1:0]           b,
  input  logic [LANES*AW-1:0]           acc,
  input  logic [1:0]                    mode,
  output logic                          out_valid,
  output logic [LANES*ELEMS*(2*EW+1)-1:0] prods,
  output logic [LANES*AW-1:0]           acc_q
);
  import dp8_pkg::*;

  localparam int unsigned PW = 2 * EW + 1;
  localparam int unsigned NP = LANES * ELEMS;
  localparam int unsigned VW = LANES * AW;

  logic                sa, sb;
  logic [NP*PW-1:0]    prod_d;

  assign sa = first_signed(mode);
  assign sb = second_signed(mode);

  for (genvar g = 0; g < NP; g++) begin : g_prod
    logic        [EW-1:0]  ra, rb;
    logic signed [EW:0]    xa, xb;
    logic signed [2*EW+1:0] full;
    assign ra   = a[g*EW +: EW];
    assign rb   = b[g*EW +: EW];
    assign xa   = {sa & ra[EW-1], ra};
    assign xb   = {sb & rb[EW-1], rb};
    assign full = xa * xb;
    assign prod_d[g*PW +: PW] = full[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (en) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      prods <= prod_d;
      acc_q <= acc;
    end
  end

  logic unused_vw;
  assign unused_vw = ^VW;

endmodule

// File: rtl/dp8_acc_stage.sv
module dp8_acc_stage #(
  parameter int unsigned EW    = 8,
  parameter int unsigned ELEMS = 4,
  parameter int unsigned LANES = 4,
  parameter int unsigned AW    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  logic                            in_valid,
  input  logic [LANES*ELEMS*(2*EW+1)-1:0] prods,
  input  logic [LANES*AW-1:0]             acc,
  output logic                            out_valid,
  output logic [LANES*AW-1:0]             res
);
  localparam int unsigned PW = 2 * EW + 1;

  logic [LANES*AW-1:0] sum_d;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [AW-1:0] tot;
    always_comb begin
      tot = acc[j*AW +: AW];
      for (int k = 0; k < ELEMS; k++) begin
        tot = tot + AW'($signed(prods[(j*ELEMS+k)*PW +: PW]));
      end
    end
    assign sum_d[j*AW +: AW] = tot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (en) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en) res <= sum_d;
  end

endmodule

// File: rtl/dp8_dot_acc.sv
module dp8_dot_acc #(
  parameter int unsigned EW    = 8,
  parameter int unsigned ELEMS = 4,
  parameter int unsigned LANES = 4,
  parameter int unsigned AW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  output logic                  op_ready,
  input  logic [LANES*AW-1:0]   op_a,
  input  logic [LANES*AW-1:0]   op_b,
  input  logic [LANES*AW-1:0]   op_acc,
  input  logic [1:0]            op_mode,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [LANES*AW-1:0]   res_data
);
  localparam int unsigned PW = 2 * EW + 1;
  localparam int unsigned NP = LANES * ELEMS;
  localparam int unsigned VW = LANES * AW;

  logic          advance;
  logic          s1_valid;
  logic [NP*PW-1:0] s1_prods;
  logic [VW-1:0] s1_acc;

  // Whole pipe moves together; it freezes only while a result is refused
  assign advance  = !res_valid || res_ready;
  assign op_ready = advance;

  dp8_mul_stage #(.EW(EW), .ELEMS(ELEMS), .LANES(LANES), .AW(AW)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (advance),
    .in_valid (op_valid),
    .a        (op_a),
    .b        (op_b),
    .acc      (op_acc),
    .mode     (op_mode),
    .out_valid(s1_valid),
    .prods    (s1_prods),
    .acc_q    (s1_acc)
  );

  dp8_acc_stage #(.EW(EW), .ELEMS(ELEMS), .LANES(LANES), .AW(AW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (advance),
    .in_valid (s1_valid),
    .prods    (s1_prods),
    .acc      (s1_acc),
    .out_valid(res_valid),
    .res      (res_data)
  );

endmodule

// File: rtl/dp8_dot_acc_chk.sv
module dp8_dot_acc_chk #(
  parameter int unsigned VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [VW-1:0] res_data
);

  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |=> !res_valid && op_ready);

  assert_latency_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_valid && op_ready) && op_ready) |-> ##1 res_valid);

  assert_no_phantom_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(op_valid && op_ready, 2));

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_data));

  assert_block_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !op_ready);

endmodule

bind dp8_dot_acc dp8_dot_acc_chk #(.VW(VW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_data (res_data)
);

// File: tb/test_dp8_dot_acc.sv
`timescale 1ns/1ps
module test_dp8_dot_acc;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic [127:0] op_a = '0, op_b = '0, op_acc = '0;
  logic [1:0]   op_mode = 2'b00;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [127:0] res_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dp8_dot_acc i_dp8_dot_acc (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready),
    .op_a(op_a), .op_b(op_b), .op_acc(op_acc), .op_mode(op_mode),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  // Stimulus table: mode, a, b, acc
  localparam int NV = 9;
  localparam logic [1:0] T_MODE [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b01, 2'b00, 2'b10, 2'b11};
  localparam logic [127:0] T_A [NV] = '{
    128'h01020304_05060708_f0f1f2f3_7f80ff00,
    128'h01020304_05060708_f0f1f2f3_7f80ff00,
    128'h01020304_05060708_f0f1f2f3_7f80ff00,
    128'h01020304_05060708_f0f1f2f3_7f80ff00,
    128'h00000003_00000500_00070000_09000000,
    128'hffffffff_ffffffff_ffffffff_ffffffff,
    128'h12345678_9abcdef0_0fedcba9_87654321,
    128'h80ff7f01_c33c5aa5_00ff00ff_deadbeef,
    128'h80ff7f01_c33c5aa5_00ff00ff_deadbeef};
  localparam logic [127:0] T_B [NV] = '{
    128'hff02fe03_80808080_10203040_7f7f7fff,
    128'hff02fe03_80808080_10203040_7f7f7fff,
    128'hff02fe03_80808080_10203040_7f7f7fff,
    128'hff02fe03_80808080_10203040_7f7f7fff,
    128'h0b0d1113_0b0d1113_0b0d1113_0b0d1113,
    128'hffffffff_ffffffff_ffffffff_ffffffff,
    128'hcafef00d_0badc0de_13579bdf_2468ace0,
    128'h7f80ff01_a55ac33c_ff00ff00_feedface,
    128'h7f80ff01_a55ac33c_ff00ff00_feedface};
  localparam logic [127:0] T_ACC [NV] = '{
    128'h00000000_00000000_00000000_00000000,
    128'h00000010_ffffffff_80000000_7fffffff,
    128'h00000000_00000001_fffffff0_12345678,
    128'h00000100_00000000_ffffffff_00000000,
    128'h00000000_00000000_00000000_00000000,
    128'hffffffff_fffc0000_00000000_7fffffff,
    128'h89abcdef_01234567_deadbeef_00000000,
    128'h7fffffff_80000000_00000000_ffffffff,
    128'h7fffffff_80000000_00000000_ffffffff};

  // Reference from the requirements: byte k of lane j at [32j+8k +: 8]
  function automatic logic [127:0] ref_dot(input logic [127:0] a, b, acc, input logic [1:0] m);
    logic [127:0] r;
    bit sgn_a, sgn_b;
    sgn_a = (m == 2'b00) || (m == 2'b11);
    sgn_b = (m == 2'b00) || (m == 2'b10);
    for (int j = 0; j < 4; j++) begin
      logic [31:0] lane;
      lane = acc[32*j +: 32];
      for (int k = 0; k < 4; k++) begin
        int ea, eb;
        ea = sgn_a ? int'($signed(a[32*j+8*k +: 8])) : int'(a[32*j+8*k +: 8]);
        eb = sgn_b ? int'($signed(b[32*j+8*k +: 8])) : int'(b[32*j+8*k +: 8]);
        lane = lane + 32'(ea * eb);
      end
      r[32*j +: 32] = lane;
    end
    return r;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One isolated operation with res_ready high; checks exact latency and value
  task automatic run_one(input string req, input logic [127:0] a, b, acc,
                         input logic [1:0] m, input logic [127:0] exp);
    @(negedge clk);
    op_valid = 1'b1; op_a = a; op_b = b; op_acc = acc; op_mode = m; res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check_bit({req, " R8 not early"}, res_valid, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check_bit({req, " R8 valid"}, res_valid, 1'b1);
    check_vec(req, res_data, exp);
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check_bit("R10 valid in reset", res_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R10 valid after reset", res_valid, 1'b0);
    check_bit("R10 ready after reset", op_ready, 1'b1);

    // Table walk: R1..R6 across modes, positions, wrap
    for (int i = 0; i < NV; i++) begin
      run_one($sformatf("R1-R6 table[%0d] mode %0d (R1 R2 R3 R4 R5 R6)", i, T_MODE[i]),
              T_A[i], T_B[i], T_ACC[i], T_MODE[i],
              ref_dot(T_A[i], T_B[i], T_ACC[i], T_MODE[i]));
    end

    // R7 extremes with hand values
    run_one("R7 R1 -128*-128", {16{8'h80}}, {16{8'h80}}, '0, 2'b00, {4{32'd65536}});
    run_one("R7 R3 255*-128",  {16{8'hff}}, {16{8'h80}}, '0, 2'b10, {4{32'hfffe0200}});
    run_one("R7 R4 -128*255",  {16{8'h80}}, {16{8'hff}}, '0, 2'b11, {4{32'hfffe0200}});
    run_one("R7 R2 255*255",   {16{8'hff}}, {16{8'hff}}, '0, 2'b01, {4{32'd260100}});
    // R6: 0x7fffffff + 4 wraps to 0x80000003
    run_one("R6 wrap", {16{8'h01}}, {16{8'h01}}, {4{32'h7fffffff}}, 2'b01, {4{32'h80000003}});
    // R5: lone byte 3 of lane 2 only touches lane 2
    run_one("R5 placement", 128'h0 | (128'h05 << 88), {16{8'h03}}, '0, 2'b01,
            128'h0 | (128'd15 << 64));

    // R8: back-to-back stream, result of slot c read in slot c+2
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        check_bit("R8 stream valid", res_valid, 1'b1);
        check_vec("R8 stream data", res_data,
                  ref_dot(T_A[c-2], T_B[c-2], T_ACC[c-2], T_MODE[c-2]));
      end
      check_bit("R8 stream ready", op_ready, 1'b1);
      if (c < 4) begin
        op_valid = 1'b1; op_a = T_A[c]; op_b = T_B[c]; op_acc = T_ACC[c]; op_mode = T_MODE[c];
      end else begin
        op_valid = 1'b0;
      end
    end

    // R9: back-pressure stall with a second operation inside the pipe
    @(negedge clk);
    res_ready = 1'b0;
    op_valid = 1'b1; op_a = T_A[6]; op_b = T_B[6]; op_acc = T_ACC[6]; op_mode = T_MODE[6];
    @(negedge clk);
    op_a = T_A[7]; op_b = T_B[7]; op_acc = T_ACC[7]; op_mode = T_MODE[7];
    @(negedge clk);
    op_valid = 1'b0;
    for (int s = 0; s < 3; s++) begin
      check_bit("R9 held valid", res_valid, 1'b1);
      check_bit("R9 input blocked", op_ready, 1'b0);
      check_vec("R9 held data", res_data, ref_dot(T_A[6], T_B[6], T_ACC[6], T_MODE[6]));
      if (s == 2) res_ready = 1'b1;
      @(negedge clk);
    end
    check_bit("R9 queued valid", res_valid, 1'b1);
    check_vec("R9 queued data", res_data, ref_dot(T_A[7], T_B[7], T_ACC[7], T_MODE[7]));
    @(negedge clk);
    check_bit("R9 drained", res_valid, 1'b0);

    // R10: reset while an operation is in flight
    op_valid = 1'b1; op_a = T_A[0]; op_b = T_B[0]; op_acc = T_ACC[0]; op_mode = T_MODE[0];
    @(negedge clk);
    op_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R10 flush valid", res_valid, 1'b0);
    check_bit("R10 flush ready", op_ready, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule